// File: doc/BRIEF.md
# Programmable-Flag Dual-Clock FIFO

This block is a first-in first-out queue whose write side and read side run on independent clocks. Each side keeps a binary pointer and publishes its Gray-coded copy to the other side through a two-flop synchronizer. Word count, free space and the four status outputs are derived from these pointers. Two offsets, one for the almost-empty threshold and one for the almost-full threshold, set where the programmable flags switch.

There are two reset inputs, both active low, and both bring the pointers back to the first slot. The full reset also reloads the configuration. While it is held, the block samples three things on the clock edges: the output mode (Standard or first-word-fall-through), the offset load method, and a default offset value taken from an eight-entry built-in table. The partial reset keeps the offsets and the mode. After reset, holding the load input high turns write-enabled cycles into offset writes and read-enabled cycles into offset readback.

In Standard mode, a word appears on the output one read-clock edge after it is requested. In first-word-fall-through mode, the oldest word is presented on the output without a request, and the read enable pops it.

Top module: `pflag_fifo`

## Requirements
- R1: While either reset is low, dout is zero, wr_ok is 1, rd_ok is 0, af_n is 1 and ae_n is 0. The same values hold after release, until a word is written.
- R2: A partial reset (prst_n low) empties the queue but keeps the offsets and the output mode held before it.
- R3: While mrst_n is low, both offsets are loaded from a default table indexed by {ld, psel[1], psel[0]}. Entry i holds 2^(i+3)-1, limited to DEPTH-1.
- R4: A word is stored at a rising wclk edge only when wen_n is 0, ld is 0 and wr_ok is 1. A write attempted while the queue is full is dropped.
- R5: In Standard mode, rd_ok is 1 exactly when the read side sees at least one word. A read (ren_n 0, ld 0, rd_ok 1) places the oldest word on dout at the next rclk edge. A read attempted while rd_ok is 0 changes nothing.
- R6: In first-word-fall-through mode, the oldest word appears on dout with rd_ok 1 and no read request. A read pops it, and on the same edge the next word takes its place if one is waiting.
- R7: wr_ok is 0 exactly when DEPTH words are held.
- R8: ae_n is 0 when the read-side occupancy is at or below the empty offset. In first-word-fall-through mode, occupancy includes the presented word.
- R9: af_n is 0 when the write-side free space is at or below the full offset.
- R10: With parallel load selected (ld low during full reset), each wclk edge with ld 1 and wen_n 0 writes din[AW-1:0]. The first such edge writes the empty offset, the next writes the full offset, and they alternate after that. The queue itself is not written.
- R11: With serial load selected (ld high during full reset), each wclk edge with ld 1 and wen_n 0 stores din[0] as the next offset bit. Bits 0..AW-1 fill the empty offset LSB first, and bits AW..2*AW-1 fill the full offset.
- R12: Each rclk edge with ld 1 and ren_n 0 shows one offset, zero-extended, on dout. The first shows the empty offset, the next the full offset, and they alternate after that. One rclk edge after ld is seen low, dout returns to the queue output.
- R13: The output mode is fwft_sel (1 = first-word-fall-through) as sampled during the full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Full reset, active low; reloads configuration |
| prst_n | input | 1 | Partial reset, active low; keeps configuration |
| fwft_sel | input | 1 | Output mode sampled during full reset |
| ld | input | 1 | Load method select in full reset; offset access afterwards |
| psel | input | 2 | Default offset select during full reset |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| din | input | DW | Write data, or offset value during load |
| dout | output | DW | Read data or offset readback |
| wr_ok | output | 1 | High while the queue has room |
| rd_ok | output | 1 | High while a word is available or presented |
| af_n | output | 1 | Almost-full, active low |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
In first-word-fall-through mode, a pop of the presented word and the refill of the output register land on the same read-clock edge. The bench provokes this by queuing two words and then issuing a single read. It passes only if dout moves straight to the second word with rd_ok staying high, and the next pop drops rd_ok. A second overlap occurs at the full boundary, where a write is attempted in the cycle wr_ok is low. A full drain then shows that the extra word never entered the queue.

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo #(
  parameter int DW = 80,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          fwft_sel,
  input  logic          ld,
  input  logic [1:0]    psel,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          af_n,
  output logic          ae_n
);
  localparam int DEPTH = 1 << AW;
  localparam int SW = $clog2(2*AW);
  localparam logic [AW:0] DEP = (AW+1)'(DEPTH);

  function automatic logic [AW-1:0] dflt(input logic [2:0] i);
    int v;
    v = (1 << (int'(i) + 3)) - 1;
    if (v > DEPTH - 1) v = DEPTH - 1;
    return v[AW-1:0];
  endfunction

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic rst_n;
  assign rst_n = mrst_n & prst_n;

  logic [DW-1:0] mem [DEPTH];
  logic [2*AW-1:0] offs;
  logic ser, phalf, fwft_q;
  logic [SW-1:0] sbit;
  logic [AW-1:0] ae_off, af_off, rbval;
  logic [AW:0] wbin, wgray, rg1, rg2, wcnt;
  logic [AW:0] rbin, rgray, wg1, wg2, rcnt, occ;
  logic [DW-1:0] dreg;
  logic ov, rbsel, show, has, do_w, pop, fill, adv;

  assign ae_off = offs[AW-1:0];
  assign af_off = offs[2*AW-1:AW];

  always_ff @(posedge wclk)
    if (!mrst_n) begin
      offs <= {2{dflt({ld, psel})}};
      ser  <= ld;
    end else if (prst_n && ld && !wen_n) begin
      if (ser)        offs[sbit] <= din[0];
      else if (phalf) offs[2*AW-1:AW] <= din[AW-1:0];
      else            offs[AW-1:0] <= din[AW-1:0];
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      sbit  <= '0;
      phalf <= 1'b0;
    end else if (ld && !wen_n) begin
      if (ser) sbit <= (sbit == SW'(2*AW-1)) ? '0 : sbit + 1'b1;
      else     phalf <= !phalf;
    end

  assign wcnt  = wbin - g2b(rg2);
  assign wr_ok = wcnt != DEP;
  assign af_n  = (DEP - wcnt) > {1'b0, af_off};
  assign do_w  = !wen_n && !ld && wr_ok;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (do_w) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end

  always_ff @(posedge wclk)
    if (do_w && rst_n) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge rclk)
    if (!mrst_n) fwft_q <= fwft_sel;

  assign rcnt  = g2b(wg2) - rbin;
  assign has   = rcnt != '0;
  assign pop   = !ren_n && !ld && ov;
  assign fill  = has && (!ov || pop);
  assign adv   = fwft_q ? fill : (!ren_n && !ld && has);
  assign occ   = rcnt + {{AW{1'b0}}, ov};
  assign rd_ok = fwft_q ? ov : has;
  assign ae_n  = occ > {1'b0, ae_off};
  assign dout  = show ? {{(DW-AW){1'b0}}, rbval} : dreg;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0;
      dreg <= '0; ov <= 1'b0; rbsel <= 1'b0; show <= 1'b0; rbval <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (adv) begin
        dreg  <= mem[rbin[AW-1:0]];
        rbin  <= rbin + 1'b1;
        rgray <= b2g(rbin + 1'b1);
      end
      ov <= fwft_q && (fill || (ov && !pop));
      if (ld && !ren_n) begin
        show  <= 1'b1;
        rbsel <= !rbsel;
        rbval <= rbsel ? af_off : ae_off;
      end else if (!ld) begin
        show <= 1'b0;
      end
    end

  // R4
  no_wr_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wen_n && !ld && !wr_ok) |=> $stable(wbin));
  // R7
  wcnt_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= DEP);
  // R5
  no_rd_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_q && !ren_n && !has) |=> $stable(rbin));
  // R5
  rcnt_bound_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rcnt <= DEP);
  // R6
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_q && ov && ren_n) |=> (ov && $stable(dreg)));
endmodule

// File: tb/test_pflag_fifo.sv
`timescale 1ns/1ps
module test_pflag_fifo;
  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, fwft_sel = 0, ld = 0, wen_n = 1, ren_n = 1;
  logic [1:0] psel = 0;
  logic [79:0] din = 0;
  logic [79:0] dout;
  logic wr_ok, rd_ok, af_n, ae_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  pflag_fifo i_pflag_fifo (.wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .ld(ld), .psel(psel), .wen_n(wen_n), .ren_n(ren_n), .din(din),
    .dout(dout), .wr_ok(wr_ok), .rd_ok(rd_ok), .af_n(af_n), .ae_n(ae_n));

  function automatic logic [79:0] mk(int k);
    return {16'(k), 64'h0123_4567_89AB_CDEF ^ 64'(k)};
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle;
    repeat (8) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic full_reset(logic fw, logic l, logic [1:0] ps);
    @(negedge wclk);
    mrst_n = 0; fwft_sel = fw; ld = l; psel = ps;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    mrst_n = 1; ld = 0; psel = 0;
    settle();
  endtask

  task automatic wr_n(int from, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); din = mk(from + i); wen_n = 0;
    end
    @(negedge wclk); wen_n = 1;
  endtask

  task automatic rd_seq(string req, int from, int n);
    @(negedge rclk); ren_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); chk(req, dout, mk(from + i));
    end
    ren_n = 1;
  endtask

  task automatic rb_chk(string req, int ae, int af);
    @(negedge rclk); ld = 1; ren_n = 0;
    @(negedge rclk); chk({req, " empty offset"}, dout, 80'(ae));
    @(negedge rclk); chk({req, " full offset"}, dout, 80'(af));
    ren_n = 1; ld = 0;
    @(negedge rclk);
  endtask

  task automatic t_reset;
    @(negedge wclk); mrst_n = 0; ld = 0; psel = 0; fwft_sel = 0;
    repeat (3) @(negedge rclk);
    chk("R1 dout in reset", dout, 0);
    chk("R1 rd_ok in reset", 80'(rd_ok), 0);
    chk("R1 wr_ok in reset", 80'(wr_ok), 1);
    @(negedge wclk); mrst_n = 1;
    settle();
    chk("R1 af_n", 80'(af_n), 1);
    chk("R1 ae_n", 80'(ae_n), 0);
    chk("R1 dout", dout, 0);
    rb_chk("R3 index 0", 7, 7);
  endtask

  task automatic t_defaults;
    full_reset(0, 0, 2'd1);
    rb_chk("R3 index 1", 15, 15);
    full_reset(0, 1, 2'd1);
    rb_chk("R3 index 5 clipped", 31, 31);
  endtask

  task automatic t_std_rw;
    full_reset(0, 0, 2'd0);
    wr_n(0, 3);
    settle();
    chk("R5 rd_ok with data", 80'(rd_ok), 1);
    chk("R5 dout before read", dout, 0);
    rd_seq("R5 std read", 0, 3);
    settle();
    chk("R5 rd_ok empty", 80'(rd_ok), 0);
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    chk("R5 read on empty", dout, mk(2));
  endtask

  task automatic t_flags;
    full_reset(0, 0, 2'd0);
    wr_n(0, 7);
    settle();
    chk("R8 ae_n at 7 words", 80'(ae_n), 0);
    wr_n(7, 1);
    settle();
    chk("R8 ae_n at 8 words", 80'(ae_n), 1);
    wr_n(8, 16);
    settle();
    chk("R9 af_n at 24 words", 80'(af_n), 1);
    wr_n(24, 1);
    settle();
    chk("R9 af_n at 25 words", 80'(af_n), 0);
    wr_n(25, 6);
    settle();
    chk("R7 wr_ok at 31 words", 80'(wr_ok), 1);
    wr_n(31, 1);
    settle();
    chk("R7 wr_ok full", 80'(wr_ok), 0);
    wr_n(99, 1);
    settle();
    rd_seq("R4 drain after dropped write", 0, 32);
    settle();
    chk("R4 nothing extra stored", 80'(rd_ok), 0);
  endtask

  task automatic t_parallel_partial;
    full_reset(0, 0, 2'd0);
    @(negedge wclk); ld = 1; wen_n = 0; din = 80'd3;
    @(negedge wclk); din = 80'd20;
    @(negedge wclk); wen_n = 1; ld = 0;
    settle();
    chk("R10 queue untouched", 80'(rd_ok), 0);
    rb_chk("R12 readback parallel", 3, 20);
    chk("R12 dout back to queue", dout, 0);
    wr_n(0, 3);
    settle();
    chk("R10 ae_n at 3", 80'(ae_n), 0);
    wr_n(3, 1);
    settle();
    chk("R10 ae_n at 4", 80'(ae_n), 1);
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst_n = 1;
    settle();
    chk("R2 rd_ok", 80'(rd_ok), 0);
    chk("R2 wr_ok", 80'(wr_ok), 1);
    chk("R2 ae_n", 80'(ae_n), 0);
    chk("R2 af_n", 80'(af_n), 1);
    chk("R2 dout", dout, 0);
    rb_chk("R2 offsets kept", 3, 20);
  endtask

  task automatic t_serial;
    logic [9:0] bits;
    bits = {5'd9, 5'd5};
    full_reset(0, 1, 2'd0);
    rb_chk("R3 index 4 clipped", 31, 31);
    for (int b = 0; b < 10; b++) begin
      @(negedge wclk); ld = 1; wen_n = 0; din = 80'(bits[b]);
    end
    @(negedge wclk); wen_n = 1; ld = 0;
    settle();
    rb_chk("R11 serial load", 5, 9);
  endtask

  task automatic t_fwft;
    full_reset(1, 0, 2'd0);
    wr_n(0, 2);
    settle();
    chk("R6 word presented", dout, mk(0));
    chk("R6 rd_ok", 80'(rd_ok), 1);
    chk("R8 fwft ae_n", 80'(ae_n), 0);
    rb_chk("R12 readback in fwft", 7, 7);
    chk("R12 presented word returns", dout, mk(0));
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    chk("R6 pop and refill", dout, mk(1));
    chk("R6 rd_ok after refill", 80'(rd_ok), 1);
    @(negedge rclk); ren_n = 0;
    @(negedge rclk); ren_n = 1;
    chk("R6 rd_ok after last pop", 80'(rd_ok), 0);
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst_n = 1;
    wr_n(5, 1);
    settle();
    chk("R13 mode kept by partial reset", dout, mk(5));
    full_reset(0, 0, 2'd0);
    wr_n(6, 1);
    settle();
    chk("R13 standard after full reset", dout, 0);
    chk("R13 rd_ok standard", 80'(rd_ok), 1);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_defaults();
    t_std_rw();
    t_flags();
    t_parallel_partial();
    t_serial();
    t_fwft();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule